// File: doc/BRIEF.md
# Five-Step Multi-Cycle RISC Core

This block is a non-pipelined 32-bit load/store processor. Each instruction runs as a fixed series of clock steps: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. Only one instruction is in flight at a time. The block holds the working registers that carry an instruction between steps: program counter, next-sequential PC, instruction word, two operands, immediate, ALU result, loaded data and branch condition. It also holds a 32-entry register file and one word-addressed memory with a single read/write port.

The memory port is shared with a host port. While `hst_en` is high the host owns the port and the core stands completely still. The testbench uses the host port during reset to load a program and data. After the program halts, it uses the same port to read back memory. A separate peek port shows any register-file entry.

Fields below are given with bit 31 as the most significant bit of the instruction word.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0, `halted` reads 0 and every register, as seen at `rf_val`, reads 0.
- R2: Field positions. The opcode is [31:26] and the first source register is [25:21]. Register-register words carry the second source in [20:16], the destination in [15:11] and the function in [10:0]. Immediate words carry the destination in [20:16] and a 16-bit immediate in [15:0], which is sign-extended. Jump words carry a 26-bit signed offset in [25:0].
- R3: When the opcode is 0x00, the function selects the operation: 1 add, 2 sub, 3 and, 4 or, 5 set-if-less-than (signed). The result goes to [15:11]. Each such instruction takes 4 steps.
- R4: Register-immediate opcodes are 0x08 add, 0x09 sub, 0x0A and, 0x0B or and 0x0C set-if-less-than. The operation combines the first source with the sign-extended immediate, and the result goes to [20:16]. Each takes 4 steps.
- R5: Load, opcode 0x10, reads the word at byte address source+immediate. The word index is address[9:2]. The loaded word goes to [20:16], and the instruction takes 5 steps.
- R6: Store, opcode 0x11, writes the register named in [20:16] to byte address source+immediate. It takes 5 steps.
- R7: Branch-if-zero is opcode 0x18 and branch-if-nonzero is opcode 0x19; both test the first source. When the condition holds, the PC becomes PC+4+immediate; otherwise it becomes PC+4. Each branch takes 4 steps. The PC changes only at the end of an instruction's last step.
- R8: Jump, opcode 0x1C, sets the PC to PC+4+offset and takes 4 steps.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: A word with opcode 0 and function 0 halts the core after 2 steps. `halted` then stays high and `pc_o` keeps the address of the halting word.
- R11: While `hst_en` is high, the core does not advance. `hst_rdata` shows the memory word at `hst_addr`, and `hst_we` writes `hst_wdata` there, whether or not reset is active.
- R12: Any other opcode, or opcode 0 with a function other than 0 to 5, writes nothing. It takes 4 steps and moves the PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of core state |
| hst_en | input | 1 | Host owns the memory port; core frozen |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host word index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Memory word at the current port address |
| rf_sel | input | 5 | Register peek select |
| rf_val | output | 32 | Value of the selected register |
| pc_o | output | 32 | Current program counter |
| halted | output | 1 | Core has reached a halt word |

## Verification
Every instruction finishes on a known rising edge: 4 steps for ALU operations, branches, jumps and unknown words, 5 for loads and stores, and 2 for the halt word. The run length from reset release to `halted` is therefore the sum of those step counts. The bench counts rising edges itself and compares the count at which `halted` is first seen. It samples only on falling edges, after the edge that completes the last step. Register, PC and memory results are read through the peek and host ports only once the core has halted, when no further edge can change them. The freeze test adds exactly the number of frozen cycles to the expected count.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMORY, ST_WRITE, ST_HALT
   } step_e;

   typedef enum logic [2:0] {
      AL_ADD, AL_SUB, AL_AND, AL_OR, AL_SLT
   } alu_e;

   typedef enum logic [3:0] {
      K_NONE, K_RR, K_RI, K_LOAD, K_STORE, K_BRZ, K_BRNZ, K_JUMP, K_HALT
   } kind_e;

   localparam logic [5:0] OP_RR   = 6'h00;
   localparam logic [5:0] OP_ADDI = 6'h08;
   localparam logic [5:0] OP_SUBI = 6'h09;
   localparam logic [5:0] OP_ANDI = 6'h0A;
   localparam logic [5:0] OP_ORI  = 6'h0B;
   localparam logic [5:0] OP_SLTI = 6'h0C;
   localparam logic [5:0] OP_LW   = 6'h10;
   localparam logic [5:0] OP_SW   = 6'h11;
   localparam logic [5:0] OP_BEQZ = 6'h18;
   localparam logic [5:0] OP_BNEZ = 6'h19;
   localparam logic [5:0] OP_JMP  = 6'h1C;

   localparam logic [10:0] FN_HALT = 11'd0;
   localparam logic [10:0] FN_ADD  = 11'd1;
   localparam logic [10:0] FN_SUB  = 11'd2;
   localparam logic [10:0] FN_AND  = 11'd3;
   localparam logic [10:0] FN_OR   = 11'd4;
   localparam logic [10:0] FN_SLT  = 11'd5;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
   import mc_pkg::*;
(
   input  logic [31:0] ir,
   output kind_e       kind,
   output alu_e        alu_op
);
   logic [5:0]  opc;
   logic [10:0] fn;

   assign opc = ir[31:26];
   assign fn  = ir[10:0];

   always_comb begin
      kind   = K_NONE;
      alu_op = AL_ADD;
      case (opc)
         OP_RR: begin
            case (fn)
               FN_HALT: kind = K_HALT;
               FN_ADD:  begin kind = K_RR; alu_op = AL_ADD; end
               FN_SUB:  begin kind = K_RR; alu_op = AL_SUB; end
               FN_AND:  begin kind = K_RR; alu_op = AL_AND; end
               FN_OR:   begin kind = K_RR; alu_op = AL_OR;  end
               FN_SLT:  begin kind = K_RR; alu_op = AL_SLT; end
               default: kind = K_NONE;
            endcase
         end
         OP_ADDI: begin kind = K_RI; alu_op = AL_ADD; end
         OP_SUBI: begin kind = K_RI; alu_op = AL_SUB; end
         OP_ANDI: begin kind = K_RI; alu_op = AL_AND; end
         OP_ORI:  begin kind = K_RI; alu_op = AL_OR;  end
         OP_SLTI: begin kind = K_RI; alu_op = AL_SLT; end
         OP_LW:   kind = K_LOAD;
         OP_SW:   kind = K_STORE;
         OP_BEQZ: kind = K_BRZ;
         OP_BNEZ: kind = K_BRNZ;
         OP_JMP:  kind = K_JUMP;
         default: kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
   import mc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go,
   input  kind_e kind,
   output step_e st,
   output logic  last_step,
   output logic  halted
);
   step_e st_q, st_d;
   logic  uses_mem, is_flow;

   assign uses_mem = (kind == K_LOAD) || (kind == K_STORE);
   assign is_flow  = (kind == K_BRZ) || (kind == K_BRNZ) || (kind == K_JUMP);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_FETCH:  st_d = ST_DECODE;
         ST_DECODE: st_d = (kind == K_HALT) ? ST_HALT : ST_EXEC;
         ST_EXEC:   st_d = (uses_mem || is_flow) ? ST_MEMORY : ST_WRITE;
         ST_MEMORY: st_d = uses_mem ? ST_WRITE : ST_FETCH;
         ST_WRITE:  st_d = ST_FETCH;
         default:   st_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q <= ST_FETCH;
      else if (go) st_q <= st_d;
   end

   assign st        = st_q;
   assign halted    = (st_q == ST_HALT);
   assign last_step = (st_q == ST_WRITE) || ((st_q == ST_MEMORY) && is_flow);

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT) |=> (st_q == ST_HALT));

   assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_FETCH) && go) |=> (st_q == ST_DECODE));

   assert_frozen_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!go) |=> $stable(st_q));
endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  alu_e            op,
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] y,
   output logic [XLEN-1:0] res
);
   logic lt;

   generate
      if (SLT_SIGNED) begin : g_slt_s
         assign lt = $signed(x) < $signed(y);
      end else begin : g_slt_u
         assign lt = x < y;
      end
   endgenerate

   always_comb begin
      case (op)
         AL_SUB:  res = x - y;
         AL_AND:  res = x & y;
         AL_OR:   res = x | y;
         AL_SLT:  res = {{(XLEN-1){1'b0}}, lt};
         default: res = x + y;
      endcase
   end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int RW   = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [RW-1:0]   ra_a,
   input  logic [RW-1:0]   ra_b,
   input  logic [RW-1:0]   ra_p,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b,
   output logic [XLEN-1:0] rd_p
);
   logic [XLEN-1:0] bank [NREG];

   assign bank[0] = '0;

   generate
      for (genvar g = 1; g < NREG; g++) begin : g_ent
         logic [XLEN-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       ent_q <= '0;
            else if (we && (wa == RW'(g)))    ent_q <= wd;
         end
         assign bank[g] = ent_q;
      end
   endgenerate

   assign rd_a = bank[ra_a];
   assign rd_b = bank[ra_b];
   assign rd_p = bank[ra_p];
endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int MEM_WORDS  = 256,
   parameter bit SLT_SIGNED = 1'b1,
   parameter int AW         = $clog2(MEM_WORDS),
   parameter int RW         = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hst_en,
   input  logic            hst_we,
   input  logic [AW-1:0]   hst_addr,
   input  logic [XLEN-1:0] hst_wdata,
   output logic [XLEN-1:0] hst_rdata,
   input  logic [RW-1:0]   rf_sel,
   output logic [XLEN-1:0] rf_val,
   output logic [XLEN-1:0] pc_o,
   output logic            halted
);
   localparam int IMM_W = 16;
   localparam int OFF_W = 26;
   localparam int STEP  = 4;

   initial begin : elab_checks
      assert (XLEN == 32) else $error("instruction fields need a 32-bit word");
      assert (NREG >= 2 && NREG <= 32 && (NREG & (NREG - 1)) == 0)
         else $error("register count must be a power of two up to 32");
      assert (MEM_WORDS >= 4 && (MEM_WORDS & (MEM_WORDS - 1)) == 0 && AW + 2 <= XLEN)
         else $error("memory depth must be a power of two that fits the address");
   end

   logic            go;
   step_e           st;
   logic            last_step;
   kind_e           kind;
   alu_e            dec_alu, alu_sel;

   logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
   logic            cond_q, cond_nxt;
   logic [XLEN-1:0] imm_ext, joff_ext, opx, opy, alu_res;
   logic [XLEN-1:0] rf_a, rf_b;
   logic            rf_we;
   logic [RW-1:0]   rf_wa;
   logic [XLEN-1:0] rf_wd;
   logic            is_flow;

   logic [XLEN-1:0] cells [MEM_WORDS];
   logic [AW-1:0]   mem_addr;
   logic            mem_we;
   logic [XLEN-1:0] mem_wdata, mem_rdata;

   assign go = !hst_en;

   mc_decode u_dec (
      .ir     (ir_q),
      .kind   (kind),
      .alu_op (dec_alu)
   );

   mc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .kind      (kind),
      .st        (st),
      .last_step (last_step),
      .halted    (halted)
   );

   // single-port memory, host has priority and freezes the core
   assign mem_addr  = hst_en ? hst_addr :
                      (st == ST_FETCH) ? pc_q[AW+1:2] : alu_q[AW+1:2];
   assign mem_we    = hst_en ? hst_we : ((st == ST_MEMORY) && (kind == K_STORE));
   assign mem_wdata = hst_en ? hst_wdata : b_q;

   always_ff @(posedge clk) begin
      if (mem_we) cells[mem_addr] <= mem_wdata;
   end
   assign mem_rdata = cells[mem_addr];
   assign hst_rdata = mem_rdata;

   mc_regfile #(.XLEN(XLEN), .NREG(NREG), .RW(RW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd),
      .ra_a  (ir_q[21 +: RW]),
      .ra_b  (ir_q[16 +: RW]),
      .ra_p  (rf_sel),
      .rd_a  (rf_a),
      .rd_b  (rf_b),
      .rd_p  (rf_val)
   );

   assign rf_we = go && (st == ST_WRITE) &&
                  ((kind == K_RR) || (kind == K_RI) || (kind == K_LOAD));
   assign rf_wa = (kind == K_RR) ? ir_q[11 +: RW] : ir_q[16 +: RW];
   assign rf_wd = (kind == K_LOAD) ? lmd_q : alu_q;

   // operand extension
   assign imm_ext  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign joff_ext = {{(XLEN-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

   // one ALU serves addresses, targets and data operations
   assign is_flow = (kind == K_BRZ) || (kind == K_BRNZ) || (kind == K_JUMP);
   assign opx     = is_flow ? npc_q : a_q;
   assign opy     = (kind == K_RR) ? b_q : (kind == K_JUMP) ? joff_ext : imm_q;
   assign alu_sel = ((kind == K_RR) || (kind == K_RI)) ? dec_alu : AL_ADD;

   mc_alu #(.XLEN(XLEN), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .op  (alu_sel),
      .x   (opx),
      .y   (opy),
      .res (alu_res)
   );

   always_comb begin
      case (kind)
         K_BRZ:   cond_nxt = (a_q == '0);
         K_BRNZ:  cond_nxt = (a_q != '0);
         K_JUMP:  cond_nxt = 1'b1;
         default: cond_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         npc_q  <= '0;
         ir_q   <= '0;
         a_q    <= '0;
         b_q    <= '0;
         imm_q  <= '0;
         alu_q  <= '0;
         lmd_q  <= '0;
         cond_q <= 1'b0;
      end else if (go) begin
         case (st)
            ST_FETCH: begin
               ir_q  <= mem_rdata;
               npc_q <= pc_q + XLEN'(STEP);
            end
            ST_DECODE: begin
               a_q   <= rf_a;
               b_q   <= rf_b;
               imm_q <= imm_ext;
            end
            ST_EXEC: begin
               alu_q  <= alu_res;
               cond_q <= cond_nxt;
            end
            ST_MEMORY: begin
               if (kind == K_LOAD) lmd_q <= mem_rdata;
               if (is_flow)        pc_q  <= cond_q ? alu_q : npc_q;
            end
            ST_WRITE: pc_q <= npc_q;
            default: ;
         endcase
      end
   end

   assign pc_o = pc_q;

   assert_r0_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_DECODE) && go && (ir_q[25:21] == 5'd0)) |=> (a_q == '0));

   assert_pc_moves_at_last_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q != $past(pc_q)) |-> $past(last_step && go));

   assert_host_freezes_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hst_en |=> $stable(pc_q));

   assert_halt_holds_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_q));
endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_en = 1'b1;
   logic        hst_we = 1'b0;
   logic [7:0]  hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic [4:0]  rf_sel = '0;
   logic [31:0] rf_val;
   logic [31:0] pc_o;
   logic        halted;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] prog [64];
   int          plen;

   always #5 clk = ~clk;

   mc_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .hst_en    (hst_en),
      .hst_we    (hst_we),
      .hst_addr  (hst_addr),
      .hst_wdata (hst_wdata),
      .hst_rdata (hst_rdata),
      .rf_sel    (rf_sel),
      .rf_val    (rf_val),
      .pc_o      (pc_o),
      .halted    (halted)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rr(input logic [10:0] fn, input logic [4:0] rd,
                                      input logic [4:0] s1, input logic [4:0] s2);
      return {6'h00, s1, s2, rd, fn};
   endfunction

   function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rd,
                                      input logic [4:0] s1, input logic [15:0] imm);
      return {op, s1, rd, imm};
   endfunction

   function automatic logic [31:0] jw(input logic [25:0] off);
      return {6'h1C, off};
   endfunction

   task automatic emit(input logic [31:0] w);
      prog[plen] = w;
      plen++;
   endtask

   // hold reset, load program through host port, check reset state (R1), release
   task automatic boot(input bit with_data);
      @(negedge clk);
      rst_n  = 1'b0;
      hst_en = 1'b1;
      hst_we = 1'b1;
      for (int k = 0; k < plen; k++) begin
         hst_addr  = 8'(k);
         hst_wdata = prog[k];
         @(negedge clk);
      end
      if (with_data) begin
         hst_addr = 8'd128; hst_wdata = 32'h0000_1234; @(negedge clk);
         hst_addr = 8'd129; hst_wdata = 32'hAAAA_5555; @(negedge clk);
      end
      hst_we = 1'b0;
      hst_en = 1'b0;
      chk("R1 pc in reset", pc_o, 32'd0);
      chk("R1 halted in reset", {31'd0, halted}, 32'd0);
      for (int r = 0; r < 32; r++) begin
         rf_sel = 5'(r);
         #1;
         chk("R1 register cleared", rf_val, 32'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // count rising edges until halted is seen; optional host freeze window
   task automatic run(input int fz_at, input int fz_len, output int cyc);
      logic [31:0] pc_fz;
      cyc   = 0;
      pc_fz = '0;
      while (!halted && cyc < 3000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (fz_len > 0 && cyc == fz_at) begin
            hst_en   = 1'b1;
            hst_we   = 1'b0;
            hst_addr = 8'd128;
            pc_fz    = pc_o;
         end
         if (fz_len > 0 && cyc == fz_at + fz_len) begin
            chk("R11 host read while running", hst_rdata, 32'h0000_1234);
            chk("R11 pc frozen", pc_o, pc_fz);
            hst_en = 1'b0;
         end
      end
      if (!halted) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not halt actual=%0d expected=halt", cyc);
      end
   endtask

   task automatic peek_reg(input logic [4:0] r, output logic [31:0] v);
      rf_sel = r;
      #1;
      v = rf_val;
   endtask

   task automatic peek_mem(input logic [7:0] a, output logic [31:0] v);
      hst_en   = 1'b1;
      hst_we   = 1'b0;
      hst_addr = a;
      #1;
      v = hst_rdata;
      @(negedge clk);
      hst_en = 1'b0;
   endtask

   task automatic build_flow();
      plen = 0;
      emit(ri(6'h08, 5'd1, 5'd0, 16'h0200));   // 0  r1 = 512
      emit(ri(6'h08, 5'd2, 5'd0, 16'hFFFB));   // 1  r2 = -5
      emit(ri(6'h11, 5'd2, 5'd1, 16'd8));      // 2  store r2 -> word 130
      emit(ri(6'h10, 5'd3, 5'd1, 16'd8));      // 3  load word 130 -> r3
      emit(ri(6'h08, 5'd0, 5'd0, 16'd99));     // 4  write r0 discarded
      emit(rr(11'd1, 5'd4, 5'd0, 5'd3));       // 5  r4 = r0 + r3
      emit(ri(6'h18, 5'd0, 5'd0, 16'd8));      // 6  beqz r0 taken -> 9
      emit(ri(6'h08, 5'd5, 5'd0, 16'd1));      // 7  skipped
      emit(ri(6'h08, 5'd5, 5'd0, 16'd2));      // 8  skipped
      emit(ri(6'h19, 5'd0, 5'd0, 16'd4));      // 9  bnez r0 not taken
      emit(ri(6'h19, 5'd0, 5'd2, 16'd4));      // 10 bnez r2 taken -> 12
      emit(ri(6'h08, 5'd6, 5'd0, 16'd3));      // 11 skipped
      emit(ri(6'h18, 5'd0, 5'd2, 16'd4));      // 12 beqz r2 not taken
      emit(jw(26'd8));                         // 13 jump -> 16
      emit(ri(6'h08, 5'd7, 5'd0, 16'd4));      // 14 skipped
      emit(ri(6'h08, 5'd7, 5'd0, 16'd5));      // 15 skipped
      emit(32'hFC00_0000);                     // 16 unknown opcode
      emit(rr(11'h7FF, 5'd8, 5'd1, 5'd2));     // 17 unknown function
      emit(ri(6'h08, 5'd9, 5'd0, 16'd7));      // 18 r9 = 7
      emit(ri(6'h08, 5'd10, 5'd10, 16'd1));    // 19 loop: r10++
      emit(ri(6'h0C, 5'd11, 5'd10, 16'd3));    // 20 r11 = r10 < 3
      emit(ri(6'h19, 5'd0, 5'd11, 16'hFFF4));  // 21 back to 19 while r11
      emit(ri(6'h11, 5'd10, 5'd1, 16'd12));    // 22 store r10 -> word 131
      emit(32'h0000_0000);                     // 23 halt
   endtask

   task automatic check_flow(input int cyc, input int extra);
      logic [31:0] v;
      // steps: 7 instr (30) + 4 flow (16) + 3 (12) + loop 9x4 (36) + store 5 + halt 2
      chk("R5 R6 R7 R8 R12 cycles to halt", 32'(cyc), 32'(101 + extra));
      chk("R10 pc holds halt word", pc_o, 32'd92);
      peek_reg(5'd3, v);  chk("R5 loaded word", v, 32'hFFFF_FFFB);
      peek_reg(5'd4, v);  chk("R9 r0 read as zero in add", v, 32'hFFFF_FFFB);
      peek_reg(5'd0, v);  chk("R9 r0 write discarded", v, 32'd0);
      peek_reg(5'd5, v);  chk("R7 beqz taken skips", v, 32'd0);
      peek_reg(5'd6, v);  chk("R7 bnez taken skips", v, 32'd0);
      peek_reg(5'd7, v);  chk("R8 jump skips", v, 32'd0);
      peek_reg(5'd8, v);  chk("R12 unknown function no write", v, 32'd0);
      peek_reg(5'd9, v);  chk("R7 fallthrough reached", v, 32'd7);
      peek_reg(5'd10, v); chk("R7 backward branch loop count", v, 32'd3);
      peek_reg(5'd11, v); chk("R4 slti final", v, 32'd0);
      peek_mem(8'd130, v); chk("R6 stored word", v, 32'hFFFF_FFFB);
      peek_mem(8'd131, v); chk("R6 second store", v, 32'd3);
      peek_mem(8'd128, v); chk("R12 data untouched", v, 32'h0000_1234);
      peek_mem(8'd129, v); chk("R12 data untouched 2", v, 32'hAAAA_5555);
   endtask

   initial begin : watchdog
      #1_500_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog global timeout actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] vals [6];
      logic [31:0] a, b, v;
      int          cyc;
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF;
      vals[3] = 16'h0007; vals[4] = 16'h7FFF; vals[5] = 16'h8000;

      // sweep register-register and register-immediate operations (R2 R3 R4)
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            plen = 0;
            emit(ri(6'h08, 5'd1, 5'd0, vals[i]));
            emit(ri(6'h08, 5'd2, 5'd0, vals[j]));
            emit(rr(11'd1, 5'd3, 5'd1, 5'd2));
            emit(rr(11'd2, 5'd4, 5'd1, 5'd2));
            emit(rr(11'd3, 5'd5, 5'd1, 5'd2));
            emit(rr(11'd4, 5'd6, 5'd1, 5'd2));
            emit(rr(11'd5, 5'd7, 5'd1, 5'd2));
            emit(ri(6'h09, 5'd8, 5'd1, vals[j]));
            emit(ri(6'h0A, 5'd9, 5'd1, vals[j]));
            emit(ri(6'h0B, 5'd10, 5'd1, vals[j]));
            emit(ri(6'h0C, 5'd11, 5'd1, vals[j]));
            emit(ri(6'h08, 5'd12, 5'd1, vals[j]));
            emit(32'h0000_0000);
            boot(1'b0);
            run(0, 0, cyc);
            a = {{16{vals[i][15]}}, vals[i]};
            b = {{16{vals[j][15]}}, vals[j]};
            chk("R3 R4 cycles 12x4+2", 32'(cyc), 32'd50);
            chk("R10 halt pc", pc_o, 32'd48);
            peek_reg(5'd1, v);  chk("R2 R4 sign-extended imm", v, a);
            peek_reg(5'd3, v);  chk("R3 add", v, a + b);
            peek_reg(5'd4, v);  chk("R3 sub", v, a - b);
            peek_reg(5'd5, v);  chk("R3 and", v, a & b);
            peek_reg(5'd6, v);  chk("R3 or", v, a | b);
            peek_reg(5'd7, v);  chk("R3 slt", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
            peek_reg(5'd8, v);  chk("R4 subi", v, a - b);
            peek_reg(5'd9, v);  chk("R4 andi", v, a & b);
            peek_reg(5'd10, v); chk("R4 ori", v, a | b);
            peek_reg(5'd11, v); chk("R4 slti", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
            peek_reg(5'd12, v); chk("R4 addi", v, a + b);
         end
      end

      // memory, branches, jump, r0, unknown words
      build_flow();
      boot(1'b1);
      run(0, 0, cyc);
      check_flow(cyc, 0);

      // halt stays with pc held (R10)
      for (int k = 0; k < 6; k++) @(negedge clk);
      chk("R10 halted sticky", {31'd0, halted}, 32'd1);
      chk("R10 pc still held", pc_o, 32'd92);

      // same program, host takes the port for 7 cycles mid-run (R11)
      boot(1'b1);
      run(20, 7, cyc);
      check_flow(cyc, 7);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule